// File: doc/BRIEF.md
# 64-bit Comparator Timer with Auto-Increment

This block is a memory-mapped timer built around a free-running 64-bit up-counter that software sees as two 32-bit words. A 64-bit compare value is checked against the counter every clock; when the counter reaches or passes it, an event flag is raised. If the interrupt enable is also set, the interrupt line goes high. With auto-increment turned on, every match adds a programmed 32-bit step to the compare value. This gives a periodic event train without software reloading the compare words after each event.

Software talks to the block over a plain single-cycle 32-bit register bus with a byte address. Reads are combinational from the current register state. A write takes effect at the clock edge that ends the bus cycle. The counter keeps running between word reads. A 64-bit value is therefore obtained by reading the high word, then the low word, then the high word again, and retrying if the two high words differ.

The comparator is a three-state machine. CMP_OFF is entered whenever the compare enable is clear, and nothing is flagged there. CMP_BELOW waits for the counter to reach the compare value. CMP_ABOVE holds after a match in one-shot use, until the counter is again below the compare value. The transitions are:

- CMP_OFF or CMP_BELOW go to CMP_ABOVE on a hit when auto-increment is off.
- CMP_OFF or CMP_BELOW go to CMP_BELOW on a hit when auto-increment is on. The compare value has just advanced.
- CMP_OFF goes to CMP_BELOW when there is no hit.
- CMP_ABOVE goes to CMP_BELOW when the hit condition drops.
- Every state goes to CMP_OFF when the compare enable is cleared.

Top module: `cmp_timer64`

## Requirements
- R1: After reset, the control word, the status word, both counter words, both compare words and the step word read as zero, and `irq` is low.
- R2: Writing a counter word replaces that word at the end of the bus cycle, and the write takes precedence over counting in that cycle. While the run bit is clear, the counter holds its value.
- R3: With the run bit set, the counter adds one per clock, and the low word carries into the high word.
- R4: Reading high, low, then high on consecutive cycles while counting returns the live value at each read. This includes a high-word change across a low-word carry, so the retry rule yields a consistent 64-bit value.
- R5: The counter wraps from all ones in both words to zero.
- R6: The event flag is status bit 0. It is set when the compare enable is on and counter >= compare value (unsigned 64-bit), including when the counter is strictly above the compare value and never equal to it.
- R7: `irq` is high exactly when the event flag, control bit 2 (interrupt enable) and control bit 1 (compare enable) are all set.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 there leaves it unchanged. A new match in the same cycle wins over the clear.
- R9: The flag is set only on entry into the >= condition. Clearing it while the counter stays at or above the compare value does not set it again. It is set again after the counter has been below the compare value.
- R10: While the compare enable (control bit 1) is clear, the flag is never set, whatever the compare words hold in between writes. Enabling compare while the counter is below the compare value does not set the flag.
- R11: With control bit 3 (auto-increment) set, each match adds the zero-extended step word to the 64-bit compare value, carrying into the high word. A compare-word write in the same cycle takes precedence over the addition.
- R12: Word offsets are 0x00 counter low, 0x04 counter high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high and 0x18 step. Control bit 0 is run, bit 1 compare enable, bit 2 interrupt enable and bit 3 auto-increment. Addresses that are not word-aligned are ignored, and unmapped reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong comparator state shows at the ports as a status flag that is set twice for one crossing, or not set again after the counter dips below the compare value. It is visible on the status read two cycles after the causing write. An auto-increment adder fault, such as a dropped carry or a doubled step, shows in the compare words on the first read after a match. A counter that fails to carry or wrap shows within one read of the boundary. The bench parks the counter at fixed values while it exercises the comparator, so every expected read is exact to the cycle.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // word indices (byte address >> 2)
    localparam int IDX_CNT  = 0;
    localparam int IDX_CTRL = 2;
    localparam int IDX_STAT = 3;
    localparam int IDX_CMP  = 4;
    localparam int IDX_STEP = 6;

    localparam int CTRL_W = 4;

    // packed so that run is bit 0 and autoinc bit 3
    typedef struct packed {
        logic autoinc;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_BELOW = 2'd1,
        CMP_ABOVE = 2'd2
    } cmp_state_e;

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [CNT_W-1:0]         cmp,
    input  logic                     flag,
    output ctrl_t                    ctrl,
    output logic [WORD_W-1:0]        step,
    output logic [CNT_W/WORD_W-1:0]  cnt_wr,
    output logic [CNT_W/WORD_W-1:0]  cmp_wr,
    output logic                     st_clr,
    output logic [WORD_W-1:0]        rdata
);
    localparam int NW    = CNT_W / WORD_W;
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             wen;

    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = addr[ADDR_W-1:2];
    assign wen     = sel && wr && aligned;

    for (genvar g = 0; g < NW; g++) begin : g_wstrobe
        assign cnt_wr[g] = wen && (idx == IDX_W'(IDX_CNT + g));
        assign cmp_wr[g] = wen && (idx == IDX_W'(IDX_CMP + g));
    end

    assign st_clr = wen && (idx == IDX_W'(IDX_STAT)) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            step <= '0;
        end else if (wen) begin
            if (idx == IDX_W'(IDX_CTRL)) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (idx == IDX_W'(IDX_STEP)) step <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            for (int g = 0; g < NW; g++) begin
                if (idx == IDX_W'(IDX_CNT + g)) rdata = cnt[g*WORD_W +: WORD_W];
                if (idx == IDX_W'(IDX_CMP + g)) rdata = cmp[g*WORD_W +: WORD_W];
            end
            if (idx == IDX_W'(IDX_CTRL)) rdata = WORD_W'(ctrl);
            if (idx == IDX_W'(IDX_STAT)) rdata = WORD_W'(flag);
            if (idx == IDX_W'(IDX_STEP)) rdata = step;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic [CNT_W/WORD_W-1:0]  wr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [CNT_W-1:0]         cnt
);
    localparam int NW = CNT_W / WORD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (|wr) begin
            for (int g = 0; g < NW; g++) begin
                if (wr[g]) cnt[g*WORD_W +: WORD_W] <= wdata;
            end
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(run && !(|wr)) |-> cnt == $past(cnt) + CNT_W'(1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !(|wr)) |=> $stable(cnt));

endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CNT_W-1:0]         cnt,
    input  logic                     cmp_en,
    input  logic                     autoinc,
    input  logic [WORD_W-1:0]        step,
    input  logic [CNT_W/WORD_W-1:0]  cmp_wr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic                     st_clr,
    output logic [CNT_W-1:0]         cmp,
    output logic                     flag
);
    localparam int NW = CNT_W / WORD_W;

    cmp_state_e state_q, state_d;
    logic       hit;
    logic       fire;

    assign hit = (cnt >= cmp);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CMP_OFF;
        else     state_q <= state_d;
    end

    // next state and match event
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            CMP_OFF, CMP_BELOW: begin
                if (hit) begin
                    fire    = 1'b1;
                    state_d = autoinc ? CMP_BELOW : CMP_ABOVE;
                end else begin
                    state_d = CMP_BELOW;
                end
            end
            CMP_ABOVE: begin
                if (!hit) state_d = CMP_BELOW;
            end
            default: state_d = CMP_OFF;
        endcase
        if (!cmp_en) begin
            state_d = CMP_OFF;
            fire    = 1'b0;
        end
    end

    // outputs: event flag and compare value
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            cmp  <= '0;
        end else begin
            if (fire)        flag <= 1'b1;
            else if (st_clr) flag <= 1'b0;

            if (|cmp_wr) begin
                for (int g = 0; g < NW; g++) begin
                    if (cmp_wr[g]) cmp[g*WORD_W +: WORD_W] <= wdata;
                end
            end else if (fire && autoinc) begin
                cmp <= cmp + CNT_W'(step);
            end
        end
    end

    // R10
    flag_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cmp_en));

    // R9
    flag_once_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CMP_ABOVE) |=> !$rose(flag));

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (st_clr && !fire) |=> !flag);

    // R11
    auto_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fire && autoinc && !(|cmp_wr)) |-> cmp == $past(cmp) + CNT_W'($past(step)));

endmodule

// File: rtl/cmp_timer64.sv
`timescale 1ns/1ps
module cmp_timer64
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int NW = CNT_W / WORD_W;

    ctrl_t             ctrl;
    logic [WORD_W-1:0] step;
    logic [NW-1:0]     cnt_wr;
    logic [NW-1:0]     cmp_wr;
    logic              st_clr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic              flag;

    tmr_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .cmp    (cmp),
        .flag   (flag),
        .ctrl   (ctrl),
        .step   (step),
        .cnt_wr (cnt_wr),
        .cmp_wr (cmp_wr),
        .st_clr (st_clr),
        .rdata  (bus_rdata)
    );

    tmr_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .wr    (cnt_wr),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    tmr_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .cmp_en  (ctrl.cmp_en),
        .autoinc (ctrl.autoinc),
        .step    (step),
        .cmp_wr  (cmp_wr),
        .wdata   (bus_wdata),
        .st_clr  (st_clr),
        .cmp     (cmp),
        .flag    (flag)
    );

    assign irq = flag && ctrl.irq_en && ctrl.cmp_en;

    // R7
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.cmp_en |-> !irq);

endmodule

// File: tb/sim_cmp_timer64.sv
`timescale 1ns/1ps
module sim_cmp_timer64;

    localparam logic [4:0] A_CLO = 5'h00;
    localparam logic [4:0] A_CHI = 5'h04;
    localparam logic [4:0] A_CTL = 5'h08;
    localparam logic [4:0] A_STA = 5'h0C;
    localparam logic [4:0] A_PLO = 5'h10;
    localparam logic [4:0] A_PHI = 5'h14;
    localparam logic [4:0] A_STP = 5'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    logic        mon_req = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          kind_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cmp_timer64 u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // driver tasks: each occupies exactly one clock cycle
    task automatic op_idle();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; mon_req = 1'b0;
    endtask

    task automatic op_wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; mon_req = 1'b0;
    endtask

    task automatic op_rd(input logic [4:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); kind_q.push_back(1'b0);
        mon_req = 1'b1;
    endtask

    task automatic op_irq(input logic e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        exp_q.push_back({31'b0, e}); tag_q.push_back(t); kind_q.push_back(1'b1);
        mon_req = 1'b1;
    endtask

    // monitor: pops one expected item per requested cycle
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] e, act;
            string t;
            bit k;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            k = kind_q.pop_front();
            act = k ? {31'b0, irq} : bus_rdata;
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, act, e);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        op_rd(A_CTL, 32'h0, "R1 ctrl");
        op_rd(A_STA, 32'h0, "R1 status");
        op_rd(A_CLO, 32'h0, "R1 cnt lo");
        op_rd(A_CHI, 32'h0, "R1 cnt hi");
        op_rd(A_PLO, 32'h0, "R1 cmp lo");
        op_rd(A_STP, 32'h0, "R1 step");
        op_irq(1'b0, "R1 irq");
        op_rd(5'h1C, 32'h0, "R12 unmapped");

        // R2 write and hold while stopped
        op_wr(A_CLO, 32'h1234_5678);
        op_wr(A_CHI, 32'h9ABC_DEF0);
        op_wr(5'h01, 32'hFFFF_FFFF);   // misaligned, ignored
        op_idle(); op_idle();
        op_rd(A_CLO, 32'h1234_5678, "R2 lo hold");
        op_rd(A_CHI, 32'h9ABC_DEF0, "R2 hi hold");

        // R3 / R4 carry and high-low-high read
        op_wr(A_CLO, 32'hFFFF_FFFE);
        op_wr(A_CHI, 32'h5);
        op_wr(A_CTL, 32'h1);
        op_rd(A_CHI, 32'h5,         "R4 first hi");
        op_rd(A_CLO, 32'hFFFF_FFFF, "R3 lo count");
        op_rd(A_CHI, 32'h6,         "R4 hi changed");
        op_rd(A_CLO, 32'h1,         "R4 retry lo");
        op_rd(A_CHI, 32'h6,         "R3 hi carry");
        op_wr(A_CTL, 32'h0);

        // R5 wrap
        op_wr(A_CLO, 32'hFFFF_FFFF);
        op_wr(A_CHI, 32'hFFFF_FFFF);
        op_wr(A_CTL, 32'h1);
        op_rd(A_CLO, 32'hFFFF_FFFF, "R5 all ones");
        op_rd(A_CHI, 32'h0,         "R5 wrapped hi");
        op_rd(A_CLO, 32'h1,         "R5 after wrap");
        op_wr(A_CTL, 32'h0);

        // R6 greater-or-equal match, R7 irq
        op_wr(A_CLO, 32'd100);
        op_wr(A_CHI, 32'd0);
        op_wr(A_PLO, 32'd50);
        op_wr(A_PHI, 32'd0);
        op_rd(A_PLO, 32'd50, "R12 cmp lo map");
        op_rd(A_STA, 32'h0, "R10 no flag while off");
        op_wr(A_CTL, 32'h6);
        op_idle();
        op_rd(A_STA, 32'h1, "R6 ge match");
        op_irq(1'b1, "R7 irq set");
        op_rd(A_CTL, 32'h6, "R12 ctrl map");

        // R8 write-one-to-clear, R9 no refire
        op_wr(A_STA, 32'h0);
        op_idle();
        op_rd(A_STA, 32'h1, "R8 write zero ignored");
        op_wr(A_STA, 32'h1);
        op_rd(A_STA, 32'h0, "R8 cleared");
        op_irq(1'b0, "R8 irq low");
        op_idle(); op_idle();
        op_rd(A_STA, 32'h0, "R9 no refire");

        // R9 rearm after dropping below
        op_wr(A_PLO, 32'd200);
        op_wr(A_PLO, 32'd90);
        op_idle();
        op_rd(A_STA, 32'h1, "R9 rearmed");
        op_wr(A_CTL, 32'h2);
        op_irq(1'b0, "R7 irq gated");
        op_rd(A_STA, 32'h1, "R7 flag kept");

        // R10 safe compare update while disabled
        op_wr(A_STA, 32'h1);
        op_wr(A_CTL, 32'h0);
        op_wr(A_PLO, 32'd200);
        op_wr(A_PLO, 32'd10);       // intermediate {0,10} below counter
        op_idle(); op_idle();
        op_rd(A_STA, 32'h0, "R10 disabled no flag");
        op_wr(A_PHI, 32'd2);
        op_wr(A_CTL, 32'h6);
        op_idle(); op_idle();
        op_rd(A_STA, 32'h0, "R10 enable below");
        op_irq(1'b0, "R10 irq low");

        // R11 auto-increment
        op_wr(A_CTL, 32'h0);
        op_wr(A_STA, 32'h1);
        op_wr(A_PLO, 32'd130);
        op_wr(A_PHI, 32'd0);
        op_wr(A_STP, 32'd30);
        op_rd(A_STP, 32'd30, "R12 step map");
        op_wr(A_CTL, 32'hA);
        op_idle();
        op_rd(A_STA, 32'h0, "R11 below no flag");
        op_wr(A_CLO, 32'd130);
        op_idle();
        op_rd(A_PLO, 32'd160, "R11 step added");
        op_rd(A_STA, 32'h1, "R11 flag");
        op_rd(A_CLO, 32'd130, "R2 stopped");
        op_idle();
        op_rd(A_PLO, 32'd160, "R11 single step");

        // R11 carry into high word
        op_wr(A_CTL, 32'h0);
        op_wr(A_STA, 32'h1);
        op_wr(A_STP, 32'h20);
        op_wr(A_PLO, 32'hFFFF_FFF0);
        op_wr(A_PHI, 32'h0);
        op_wr(A_CLO, 32'hFFFF_FFF0);
        op_wr(A_CHI, 32'h0);
        op_wr(A_CTL, 32'hA);
        op_idle();
        op_rd(A_PLO, 32'h10, "R11 carry lo");
        op_rd(A_PHI, 32'h1,  "R11 carry hi");
        op_rd(A_STA, 32'h1,  "R11 carry flag");

        op_idle(); op_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule